// File: doc/BRIEF.md
# Radix-Adjusted Memory Increment Unit

This unit executes the "increment a data-memory nibble in a chosen radix" operations of a small 4-bit processor. It accepts a 13-bit instruction word over a valid/ready stream and recognises the four forms of the operation. For each form it reads one nibble from data memory and adds one. The sum is reduced modulo a radix between 1 and 16, which the word encodes. The result is written back, and the carry and zero flags are updated. Two forms then advance the index register they used.

The memory address normally comes from one of two 16-bit index registers, called first and second. A one-shot extension prefix can be loaded through plain control pins. It holds an 8-bit offset. When the prefix is pending, the non-advancing forms use an absolute address instead: page 00H for the first-index form, or page FFH for the second-index form. Every instruction the unit accepts consumes the pending prefix.

The stream has one back-pressure rule: `instr_ready` is high only while the unit is idle. A word is taken on a clock edge where `instr_valid` and `instr_ready` are both high. The unit then holds `instr_ready` low for exactly one further cycle. The producer must keep `instr_valid` and `instr_word` steady until the word is taken. This gives at most one instruction every two cycles.

Top module: `radix_inc_unit`

## Requirements
- R1: A word is recognised when bits [12:6] equal 7'b1110110. Bit 5 selects the second index register (0 selects the first), and bit 4 selects the advancing form. Any other accepted word causes no memory access, leaves C, Z and both index registers unchanged, and still consumes a pending prefix.
- R2: `instr_ready` is 1 only in the idle state. A word accepted at an edge makes the next cycle busy, with `instr_ready` at 0. For a recognised word, `mem_rd` is high in the accept cycle and `mem_wr` is high in the busy cycle, at the same address. Read data arrives one cycle after `mem_rd`.
- R3: The radix is 16 minus bits [3:0] of the word. A field value of 0 means radix 16, and a value of 15 means radix 1.
- R4: With d the nibble read and n the radix: if d+1 >= n, the unit writes d+1-n and sets C. Otherwise it writes d+1 and clears C.
- R5: Z is set exactly when the written nibble is 0. C and Z change only when a recognised instruction completes.
- R6: After its write, an advancing form adds one to the index register it used, wrapping from FFFFH to 0000H. This does not touch C or Z.
- R7: While a prefix is pending, a non-advancing first-index form addresses {00H, imm}, and a non-advancing second-index form addresses {FFH, imm}.
- R8: The advancing forms always address through their index register, even while a prefix is pending.
- R9: A pulse on `ext_set` stores `ext_imm` and sets `flag_e`. `flag_e` clears at the completing edge of any accepted word. An `ext_set` at that same edge wins, and `flag_e` stays 1.
- R10: `idx_wr_x` or `idx_wr_y` loads `idx_wdata` into the first or second index register. A load at the same edge as that register's post-increment wins.
- R11: After reset: both index registers are 0, C, Z and E are 0, `instr_ready` is 1, and there are no memory strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle, can take a word |
| instr_word | input | 13 | Instruction word |
| ext_set | input | 1 | Load the extension prefix |
| ext_imm | input | IMM_W | Prefix offset |
| idx_wr_x | input | 1 | Load first index register |
| idx_wr_y | input | 1 | Load second index register |
| idx_wdata | input | ADDR_W | Index load value |
| x_out | output | ADDR_W | First index register |
| y_out | output | ADDR_W | Second index register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_rdata | input | 4 | Read data, one cycle after mem_rd |
| mem_wdata | output | 4 | Write data |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_e | output | 1 | Extension prefix pending |

## Verification
Two pairs of functions can meet on the same completing edge. An external index load can coincide with the post-increment of that same register. A fresh prefix load can coincide with the consumption of the old prefix. The bench provokes both by driving `idx_wr_x` and `ext_set` during the busy cycle of an advancing first-index instruction. After that edge, the bench's behavioural model expects `x_out` to hold the loaded value, not the incremented one. It also expects `flag_e` to stay set, and the next non-advancing instruction to use the new offset.

// File: rtl/rinc_pkg.sv
package rinc_pkg;
  localparam int NIB_W  = 4;
  localparam int WORD_W = 13;
  localparam int RAD_W  = NIB_W + 1;
  localparam logic [6:0] OP_MATCH = 7'b1110110;

  typedef enum logic {ST_IDLE, ST_BUSY} rinc_state_t;

  typedef struct packed {
    logic             hit;
    logic             use_y;
    logic             post;
    logic [RAD_W-1:0] radix;
  } rinc_dec_t;
endpackage

// File: rtl/rinc_decode.sv
module rinc_decode
  import rinc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output rinc_dec_t         dec
);
  always_comb begin
    dec.hit   = (word[12:6] == OP_MATCH);
    dec.use_y = word[5];
    dec.post  = word[4];
    dec.radix = RAD_W'(16) - {1'b0, word[3:0]};
  end
endmodule

// File: rtl/rinc_adjust.sv
module rinc_adjust
  import rinc_pkg::*;
(
  input  logic [NIB_W-1:0] din,
  input  logic [RAD_W-1:0] radix,
  output logic [NIB_W-1:0] dout,
  output logic             carry,
  output logic             zero
);
  logic [RAD_W-1:0] sum;
  logic [RAD_W-1:0] red;

  always_comb begin
    sum = {1'b0, din} + RAD_W'(1);
    if (sum >= radix) begin
      red   = sum - radix;
      carry = 1'b1;
    end else begin
      red   = sum;
      carry = 1'b0;
    end
    dout = red[NIB_W-1:0];
    zero = (dout == '0);
  end

  always_comb begin
    if (radix != '0 && din < radix && radix <= RAD_W'(16))
      a_inrange_r4: assert (dout < radix[NIB_W-1:0] || radix == RAD_W'(16));
  end
endmodule

// File: rtl/rinc_index_regs.sv
module rinc_index_regs #(
  parameter int ADDR_W  = 16,
  parameter int NUM_IDX = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_IDX-1:0]              ld,
  input  logic [NUM_IDX-1:0]              inc,
  input  logic [ADDR_W-1:0]               ld_data,
  output logic [NUM_IDX-1:0][ADDR_W-1:0]  idx
);
  for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx[g] <= '0;
      else if (ld[g])  idx[g] <= ld_data;
      else if (inc[g]) idx[g] <= idx[g] + 1'b1;
    end

    p_postinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[g] && !ld[g]) |=> idx[g] == $past(idx[g]) + 1'b1);

    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld[g] |=> idx[g] == $past(ld_data));
  end
endmodule

// File: rtl/radix_inc_unit.sv
module radix_inc_unit
  import rinc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  output logic                 instr_ready,
  input  logic [WORD_W-1:0]    instr_word,
  input  logic                 ext_set,
  input  logic [IMM_W-1:0]     ext_imm,
  input  logic                 idx_wr_x,
  input  logic                 idx_wr_y,
  input  logic [ADDR_W-1:0]    idx_wdata,
  output logic [ADDR_W-1:0]    x_out,
  output logic [ADDR_W-1:0]    y_out,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [NIB_W-1:0]     mem_rdata,
  output logic [NIB_W-1:0]     mem_wdata,
  output logic                 flag_c,
  output logic                 flag_z,
  output logic                 flag_e
);
  localparam int PAGE_W = ADDR_W - IMM_W;

  rinc_state_t st;
  rinc_dec_t   dec_in, dec_q;
  logic [ADDR_W-1:0] addr_q, ea;
  logic [IMM_W-1:0]  imm_q;
  logic accept, busy, busy_hit;
  logic adj_c, adj_z;
  logic [1:0] idx_ld, idx_inc;
  logic [1:0][ADDR_W-1:0] idx;

  rinc_decode u_dec (.word(instr_word), .dec(dec_in));

  assign busy        = (st == ST_BUSY);
  assign instr_ready = !busy;
  assign accept      = instr_valid && !busy;
  assign busy_hit    = busy && dec_q.hit;

  always_comb begin
    if (!dec_in.post && flag_e)
      ea = {{PAGE_W{dec_in.use_y}}, imm_q};
    else
      ea = dec_in.use_y ? idx[1] : idx[0];
  end

  assign mem_rd   = accept && dec_in.hit;
  assign mem_wr   = busy_hit;
  assign mem_addr = busy ? addr_q : ea;

  rinc_adjust u_adj (
    .din  (mem_rdata),
    .radix(dec_q.radix),
    .dout (mem_wdata),
    .carry(adj_c),
    .zero (adj_z)
  );

  assign idx_ld  = {idx_wr_y, idx_wr_x};
  assign idx_inc = {busy_hit && dec_q.post && dec_q.use_y,
                    busy_hit && dec_q.post && !dec_q.use_y};

  rinc_index_regs #(.ADDR_W(ADDR_W), .NUM_IDX(2)) u_idx (
    .clk(clk), .rst_n(rst_n), .ld(idx_ld), .inc(idx_inc),
    .ld_data(idx_wdata), .idx(idx)
  );

  assign x_out = idx[0];
  assign y_out = idx[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      dec_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      st     <= ST_BUSY;
      dec_q  <= dec_in;
      addr_q <= ea;
    end else begin
      st     <= ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_c <= 1'b0;
      flag_z <= 1'b0;
    end else if (busy_hit) begin
      flag_c <= adj_c;
      flag_z <= adj_z;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_e <= 1'b0;
      imm_q  <= '0;
    end else if (ext_set) begin
      flag_e <= 1'b1;
      imm_q  <= ext_imm;
    end else if (busy) begin
      flag_e <= 1'b0;
    end
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !instr_ready);

  p_write_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && mem_addr == $past(mem_addr)));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (flag_z == ($past(mem_wdata) == '0)));

  p_miss_keeps_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dec_q.hit) |=> ($stable(flag_c) && $stable(flag_z)));

  p_prefix_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ext_set) |=> !flag_e);
endmodule

// File: tb/test_radix_inc_unit.sv
module test_radix_inc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic instr_ready;
  logic [12:0] instr_word = '0;
  logic ext_set = 1'b0;
  logic [7:0] ext_imm = '0;
  logic idx_wr_x = 1'b0, idx_wr_y = 1'b0;
  logic [15:0] idx_wdata = '0;
  logic [15:0] x_out, y_out, mem_addr;
  logic mem_rd, mem_wr, flag_c, flag_z, flag_e;
  logic [3:0] mem_rdata = '0;
  logic [3:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;

  logic [3:0] mem [int];
  logic [3:0] exp_mem [int];
  int x_m = 0, y_m = 0, imm_m = 0;
  bit c_m = 0, z_m = 0, e_m = 0;

  always #5 clk = ~clk;

  radix_inc_unit i_radix_inc_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .ext_set(ext_set), .ext_imm(ext_imm),
    .idx_wr_x(idx_wr_x), .idx_wr_y(idx_wr_y), .idx_wdata(idx_wdata),
    .x_out(x_out), .y_out(y_out), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .flag_c(flag_c), .flag_z(flag_z), .flag_e(flag_e));

  function automatic logic [3:0] rd_bench(int a);
    return mem.exists(a) ? mem[a] : 4'h0;
  endfunction

  function automatic logic [3:0] rd_model(int a);
    return exp_mem.exists(a) ? exp_mem[a] : 4'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) mem_rdata <= rd_bench(int'(mem_addr));
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(flag_c == c_m, "R4 carry", flag_c, c_m);
      chk(flag_z == z_m, "R5 zero", flag_z, z_m);
      chk(flag_e == e_m, "R9 prefix flag", flag_e, e_m);
      chk(int'(x_out) == x_m, "R6 first index", x_out, x_m);
      chk(int'(y_out) == y_m, "R6 second index", y_out, y_m);
    end
  end

  task automatic poke(int a, logic [3:0] v);
    mem[a] = v;
    exp_mem[a] = v;
  endtask

  task automatic load_idx(bit sel_y, int v);
    @(negedge clk);
    idx_wdata = 16'(v);
    if (sel_y) idx_wr_y = 1'b1; else idx_wr_x = 1'b1;
    @(posedge clk); #1;
    idx_wr_x = 1'b0; idx_wr_y = 1'b0;
    if (sel_y) y_m = v; else x_m = v;
  endtask

  task automatic set_ext(int v);
    @(negedge clk);
    ext_set = 1'b1; ext_imm = 8'(v);
    @(posedge clk); #1;
    ext_set = 1'b0;
    e_m = 1; imm_m = v;
  endtask

  task automatic run(logic [12:0] w, bit ld_b, int ld_v, bit ext_b, int ext_v);
    bit hit, use_y, post;
    int ea, n, d, s, v;
    bit c;
    hit   = (w[12:6] == 7'b1110110);
    use_y = w[5];
    post  = w[4];
    n     = 16 - int'(w[3:0]);
    if (!post && e_m) ea = use_y ? (32'hFF00 | imm_m) : imm_m;
    else              ea = use_y ? y_m : x_m;
    d = rd_model(ea);
    s = d + 1;
    if (s >= n) begin v = s - n; c = 1; end else begin v = s; c = 0; end
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    #1;
    chk(instr_ready == 1'b1, "R2 ready idle", instr_ready, 1);
    chk(mem_rd == hit, "R1 read strobe", mem_rd, hit);
    if (hit) chk(int'(mem_addr) == ea, "R7/R8 address R7 R8", mem_addr, ea);
    @(posedge clk); #1;
    instr_valid = 1'b0;
    @(negedge clk);
    chk(instr_ready == 1'b0, "R2 busy", instr_ready, 0);
    chk(mem_wr == hit, "R2 write strobe", mem_wr, hit);
    if (hit) begin
      chk(int'(mem_addr) == ea, "R2 write address", mem_addr, ea);
      chk(int'(mem_wdata) == v, "R4 write data R3", mem_wdata, v);
    end
    if (ld_b) begin idx_wr_x = 1'b1; idx_wdata = 16'(ld_v); end
    if (ext_b) begin ext_set = 1'b1; ext_imm = 8'(ext_v); end
    @(posedge clk); #1;
    idx_wr_x = 1'b0; ext_set = 1'b0;
    if (hit) begin
      exp_mem[ea] = 4'(v);
      c_m = c; z_m = (v == 0);
      if (post) begin
        if (use_y) y_m = (y_m + 1) & 32'hFFFF;
        else       x_m = (x_m + 1) & 32'hFFFF;
      end
      chk(rd_bench(ea) == rd_model(ea), "R4 memory", rd_bench(ea), rd_model(ea));
    end
    if (ld_b) x_m = ld_v;
    if (ext_b) begin e_m = 1; imm_m = ext_v; end
    else e_m = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(instr_ready == 1'b1, "R11 ready", instr_ready, 1);
    chk(!mem_rd && !mem_wr, "R11 strobes", {mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    @(negedge clk);

    load_idx(0, 16'h0010);
    poke(16'h0010, 4'd3);
    run(13'h1D86, 0, 0, 0, 0);          // R4 radix 10, 3 -> 4
    poke(16'h0010, 4'd9);
    run(13'h1D86, 0, 0, 0, 0);          // R4 R5 radix 10, 9 -> 0 carry
    poke(16'h0010, 4'd15);
    run(13'h1D80, 0, 0, 0, 0);          // R3 field 0 is radix 16
    poke(16'h0010, 4'd0);
    run(13'h1D8F, 0, 0, 0, 0);          // R3 radix 1
    poke(16'h0010, 4'd5);
    run(13'h1D89, 0, 0, 0, 0);          // radix 7, no carry

    load_idx(1, 16'h2005);
    poke(16'h2005, 4'd7);
    run(13'h1DA8, 0, 0, 0, 0);          // R1 second index, radix 8
    run(13'h1DB4, 0, 0, 0, 0);          // R6 advancing second index

    load_idx(0, 16'hFFFF);
    poke(16'hFFFF, 4'd2);
    run(13'h1D9D, 0, 0, 0, 0);          // R6 wrap to 0000H, radix 3

    set_ext(8'h34);
    poke(16'h0034, 4'd6);
    run(13'h1D8A, 0, 0, 0, 0);          // R7 page 00H
    set_ext(8'h34);
    poke(16'hFF34, 4'd11);
    run(13'h1DA4, 0, 0, 0, 0);          // R7 page FFH, radix 12 carry
    set_ext(8'h56);
    poke(16'h0000, 4'd1);
    run(13'h1D90, 0, 0, 0, 0);          // R8 advancing form ignores prefix

    set_ext(8'h12);
    run(13'h0123, 0, 0, 0, 0);          // R1 unrecognised word, prefix consumed
    run(13'h1DC0, 0, 0, 0, 0);          // R1 neighbour opcode rejected

    load_idx(0, 16'h0100);
    poke(16'h0100, 4'd4);
    run(13'h1D96, 1, 16'h0200, 1, 8'h77); // R10 load wins, R9 new prefix wins
    poke(16'h0077, 4'd8);
    run(13'h1D86, 0, 0, 0, 0);          // R9 new offset used
    run(13'h1D86, 0, 0, 0, 0);          // R7 prefix gone, address from index

    @(negedge clk);
    chk_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule